// File: doc/BRIEF.md
# Logical-to-Physical Block Map with Unmap Support

This block is the translation table of a flash controller. The host names storage by logical block address (LBA). The table turns each LBA into the physical block address (PBA) that the flash array uses. A bind operation ties an LBA to a fresh PBA that an external allocator grants. When that LBA already held a PBA, the old one is handed back to the allocator as free. A trim (unmap) operation clears the binding and also returns the PBA. A physical block stays in use from the moment it is written until a trim or an overwrite lets it go, whatever the file system above has done with the file.

A separate lookup port answers translation queries one cycle after each request. The answer states whether the LBA is mapped and, if so, its PBA. For an unmapped LBA the response also carries a fill word, which is the data the read path should return in place of flash content. With the zero-fill option set, the fill word is always zero. With it clear, the fill word is a pattern captured while reset is held. That pattern never changes afterwards, so repeated reads of an unmapped LBA always see the same data until the LBA is written again. The table depth is set by the LBA width parameter. The allocation policy and the data path are outside this block.

Top module: `l2p_map`

## Requirements
- R1: After reset every LBA is unmapped. A lookup of any LBA returns rsp_mapped=0 and rel_valid stays low until an update is accepted.
- R2: An update with upd_trim=0 is a bind. A bind raises alloc_req and is accepted only in a cycle with alloc_gnt=1. upd_ready equals upd_trim OR alloc_gnt while upd_valid is high.
- R3: An accepted bind maps upd_lba to alloc_pba. Later lookups of that LBA return rsp_mapped=1 and rsp_pba equal to that PBA.
- R4: An accepted bind to an LBA that was already mapped sets rel_valid=1 with rel_pba equal to the old PBA in the next cycle. A bind to an unmapped LBA releases nothing.
- R5: An update with upd_trim=1 is a trim and is always accepted. It unmaps the LBA. If the LBA was mapped, rel_valid=1 and rel_pba equals its PBA in the next cycle. If it was not mapped, nothing is released.
- R6: rsp_valid is high in the cycle after a cycle with lk_valid high, and low otherwise.
- R7: A lookup in the same cycle as an accepted update to the same LBA returns the state after the update: the new PBA for a bind, unmapped for a trim.
- R8: When cfg_zero_fill was 1 in the lookup cycle, an unmapped response carries rsp_fill=0.
- R9: When cfg_zero_fill was 0, an unmapped response carries rsp_fill equal to the fill_seed value present on the last reset cycle. Later changes of fill_seed have no effect.
- R10: An unmapped response has rsp_pba=0, and a mapped response has rsp_fill=0.
- R11: A bind held without alloc_gnt changes no mapping and releases nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; fill_seed is captured while high |
| cfg_zero_fill | input | 1 | 1: unmapped reads return zero fill; 0: return the captured pattern |
| fill_seed | input | FILL_W | Pattern for unmapped reads, sampled during reset |
| upd_valid | input | 1 | Update request |
| upd_trim | input | 1 | 1: trim (unmap); 0: bind to a newly allocated PBA |
| upd_lba | input | LBA_W | LBA to update |
| upd_ready | output | 1 | Update accepted this cycle when upd_valid is high |
| alloc_req | output | 1 | Request for a free PBA from the allocator |
| alloc_gnt | input | 1 | Allocator grant; alloc_pba is valid |
| alloc_pba | input | PBA_W | Granted PBA |
| rel_valid | output | 1 | A PBA is returned to the free pool |
| rel_pba | output | PBA_W | Released PBA |
| lk_valid | input | 1 | Lookup request |
| lk_lba | input | LBA_W | LBA to translate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_mapped | output | 1 | LBA has a binding |
| rsp_pba | output | PBA_W | Translated PBA, zero when unmapped |
| rsp_fill | output | FILL_W | Substitute data word for an unmapped LBA, zero when mapped |

## Verification
The bench builds the block with LBA_W=3 (eight entries), PBA_W=8 and FILL_W=16. With only eight LBAs, random traffic hits each entry often. This brings into reach overwrites that release an old PBA, repeated trims of the same entry, and a lookup landing on the LBA that is being updated in the same cycle. The small depth also lets directed phases sweep the whole table after each reset, and it exercises both fill modes together with a fill_seed that changes after reset.

// File: rtl/l2p_pkg.sv
package l2p_pkg;

    typedef enum logic [1:0] {
        UPD_IDLE = 2'd0,
        UPD_BIND = 2'd1,
        UPD_DROP = 2'd2
    } upd_kind_e;

    // Classify an update request: trims are always taken, binds need a grant.
    function automatic upd_kind_e classify_upd(logic vld, logic trim, logic gnt);
        if (!vld)       return UPD_IDLE;
        if (trim)       return UPD_DROP;
        if (gnt)        return UPD_BIND;
        return UPD_IDLE;
    endfunction

endpackage

// File: rtl/l2p_table.sv
module l2p_table #(
    parameter int LBA_W = 6,
    parameter int PBA_W = 12,
    localparam int DEPTH = 1 << LBA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LBA_W-1:0] wr_lba,
    input  logic             wr_set,
    input  logic [PBA_W-1:0] wr_pba,
    input  logic [LBA_W-1:0] ra_lba,
    output logic             ra_valid,
    output logic [PBA_W-1:0] ra_pba,
    input  logic [LBA_W-1:0] rb_lba,
    output logic             rb_valid,
    output logic [PBA_W-1:0] rb_pba
);

    logic [DEPTH-1:0] ent_vld;
    logic [PBA_W-1:0] ent_pba [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic hit;
        assign hit = wr_en && (wr_lba == LBA_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_vld[g] <= 1'b0;
                ent_pba[g] <= '0;
            end else if (hit) begin
                ent_vld[g] <= wr_set;
                ent_pba[g] <= wr_set ? wr_pba : '0;
            end
        end
    end

    assign ra_valid = ent_vld[ra_lba];
    assign ra_pba   = ent_pba[ra_lba];
    assign rb_valid = ent_vld[rb_lba];
    assign rb_pba   = ent_pba[rb_lba];

endmodule

// File: rtl/l2p_update.sv
module l2p_update
    import l2p_pkg::*;
#(
    parameter int LBA_W = 6,
    parameter int PBA_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid,
    input  logic             upd_trim,
    input  logic             alloc_gnt,
    input  logic [PBA_W-1:0] alloc_pba,
    input  logic             old_valid,
    input  logic [PBA_W-1:0] old_pba,
    output logic             alloc_req,
    output logic             upd_ready,
    output upd_kind_e        kind,
    output logic             tbl_wr_en,
    output logic             tbl_wr_set,
    output logic [PBA_W-1:0] tbl_wr_pba,
    output logic             rel_valid,
    output logic [PBA_W-1:0] rel_pba
);

    assign kind       = classify_upd(upd_valid, upd_trim, alloc_gnt);
    assign alloc_req  = upd_valid && !upd_trim;
    assign upd_ready  = upd_trim || alloc_gnt;
    assign tbl_wr_en  = (kind != UPD_IDLE);
    assign tbl_wr_set = (kind == UPD_BIND);
    assign tbl_wr_pba = alloc_pba;

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_valid <= 1'b0;
            rel_pba   <= '0;
        end else begin
            rel_valid <= tbl_wr_en && old_valid;
            rel_pba   <= (tbl_wr_en && old_valid) ? old_pba : '0;
        end
    end

endmodule

// File: rtl/l2p_lookup.sv
module l2p_lookup
    import l2p_pkg::*;
#(
    parameter int LBA_W  = 6,
    parameter int PBA_W  = 12,
    parameter int FILL_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_zero_fill,
    input  logic [FILL_W-1:0] fill_seed,
    input  logic              lk_valid,
    input  logic [LBA_W-1:0]  lk_lba,
    input  logic              tbl_valid,
    input  logic [PBA_W-1:0]  tbl_pba,
    input  upd_kind_e         kind,
    input  logic [LBA_W-1:0]  upd_lba,
    input  logic [PBA_W-1:0]  new_pba,
    output logic [FILL_W-1:0] seed_q,
    output logic              rsp_valid,
    output logic              rsp_mapped,
    output logic [PBA_W-1:0]  rsp_pba,
    output logic [FILL_W-1:0] rsp_fill
);

    logic             same;
    logic             eff_valid;
    logic [PBA_W-1:0] eff_pba;

    assign same = (kind != UPD_IDLE) && (upd_lba == lk_lba);

    always_comb begin
        eff_valid = tbl_valid;
        eff_pba   = tbl_pba;
        if (same) begin
            eff_valid = (kind == UPD_BIND);
            eff_pba   = new_pba;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q     <= fill_seed;
            rsp_valid  <= 1'b0;
            rsp_mapped <= 1'b0;
            rsp_pba    <= '0;
            rsp_fill   <= '0;
        end else begin
            rsp_valid  <= lk_valid;
            rsp_mapped <= eff_valid;
            rsp_pba    <= eff_valid ? eff_pba : '0;
            if (eff_valid || cfg_zero_fill) rsp_fill <= '0;
            else                            rsp_fill <= seed_q;
        end
    end

endmodule

// File: rtl/l2p_map.sv
module l2p_map
    import l2p_pkg::*;
#(
    parameter int LBA_W  = 6,
    parameter int PBA_W  = 12,
    parameter int FILL_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_zero_fill,
    input  logic [FILL_W-1:0] fill_seed,
    input  logic              upd_valid,
    input  logic              upd_trim,
    input  logic [LBA_W-1:0]  upd_lba,
    output logic              upd_ready,
    output logic              alloc_req,
    input  logic              alloc_gnt,
    input  logic [PBA_W-1:0]  alloc_pba,
    output logic              rel_valid,
    output logic [PBA_W-1:0]  rel_pba,
    input  logic              lk_valid,
    input  logic [LBA_W-1:0]  lk_lba,
    output logic              rsp_valid,
    output logic              rsp_mapped,
    output logic [PBA_W-1:0]  rsp_pba,
    output logic [FILL_W-1:0] rsp_fill
);

    upd_kind_e        kind;
    logic             wr_en, wr_set;
    logic [PBA_W-1:0] wr_pba;
    logic             old_valid, lk_tbl_valid;
    logic [PBA_W-1:0] old_pba, lk_tbl_pba;
    logic [FILL_W-1:0] seed_q;

    l2p_table #(.LBA_W(LBA_W), .PBA_W(PBA_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_lba   (upd_lba),
        .wr_set   (wr_set),
        .wr_pba   (wr_pba),
        .ra_lba   (upd_lba),
        .ra_valid (old_valid),
        .ra_pba   (old_pba),
        .rb_lba   (lk_lba),
        .rb_valid (lk_tbl_valid),
        .rb_pba   (lk_tbl_pba)
    );

    l2p_update #(.LBA_W(LBA_W), .PBA_W(PBA_W)) u_update (
        .clk        (clk),
        .rst        (rst),
        .upd_valid  (upd_valid),
        .upd_trim   (upd_trim),
        .alloc_gnt  (alloc_gnt),
        .alloc_pba  (alloc_pba),
        .old_valid  (old_valid),
        .old_pba    (old_pba),
        .alloc_req  (alloc_req),
        .upd_ready  (upd_ready),
        .kind       (kind),
        .tbl_wr_en  (wr_en),
        .tbl_wr_set (wr_set),
        .tbl_wr_pba (wr_pba),
        .rel_valid  (rel_valid),
        .rel_pba    (rel_pba)
    );

    l2p_lookup #(.LBA_W(LBA_W), .PBA_W(PBA_W), .FILL_W(FILL_W)) u_lookup (
        .clk           (clk),
        .rst           (rst),
        .cfg_zero_fill (cfg_zero_fill),
        .fill_seed     (fill_seed),
        .lk_valid      (lk_valid),
        .lk_lba        (lk_lba),
        .tbl_valid     (lk_tbl_valid),
        .tbl_pba       (lk_tbl_pba),
        .kind          (kind),
        .upd_lba       (upd_lba),
        .new_pba       (wr_pba),
        .seed_q        (seed_q),
        .rsp_valid     (rsp_valid),
        .rsp_mapped    (rsp_mapped),
        .rsp_pba       (rsp_pba),
        .rsp_fill      (rsp_fill)
    );

endmodule

// File: rtl/l2p_map_chk.sv
module l2p_map_chk #(
    parameter int PBA_W  = 12,
    parameter int FILL_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_zero_fill,
    input logic              upd_valid,
    input logic              upd_trim,
    input logic              upd_ready,
    input logic              alloc_gnt,
    input logic              rel_valid,
    input logic              lk_valid,
    input logic              rsp_valid,
    input logic              rsp_mapped,
    input logic [PBA_W-1:0]  rsp_pba,
    input logic [FILL_W-1:0] rsp_fill,
    input logic [FILL_W-1:0] seed_q
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rel_valid && !rsp_valid));

    // R2
    bind_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_trim && !alloc_gnt) |-> !upd_ready);

    // R11
    no_release_without_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_trim && !alloc_gnt) |=> !rel_valid);

    // R6
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R6
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    // R10
    unmapped_pba_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_mapped) |-> (rsp_pba == '0));

    // R10
    mapped_fill_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_mapped) |-> (rsp_fill == '0));

    // R8
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && cfg_zero_fill) |=> (rsp_mapped || rsp_fill == '0));

    // R9
    seed_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(seed_q));

endmodule

bind l2p_map l2p_map_chk #(.PBA_W(PBA_W), .FILL_W(FILL_W)) u_l2p_map_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_zero_fill (cfg_zero_fill),
    .upd_valid     (upd_valid),
    .upd_trim      (upd_trim),
    .upd_ready     (upd_ready),
    .alloc_gnt     (alloc_gnt),
    .rel_valid     (rel_valid),
    .lk_valid      (lk_valid),
    .rsp_valid     (rsp_valid),
    .rsp_mapped    (rsp_mapped),
    .rsp_pba       (rsp_pba),
    .rsp_fill      (rsp_fill),
    .seed_q        (seed_q)
);

// File: tb/test_l2p_map.sv
module test_l2p_map;

    localparam int LBA_W  = 3;
    localparam int PBA_W  = 8;
    localparam int FILL_W = 16;
    localparam int DEPTH  = 1 << LBA_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_zero_fill = 1'b0;
    logic [FILL_W-1:0] fill_seed = 16'hA5C3;
    logic              upd_valid = 1'b0, upd_trim = 1'b0;
    logic [LBA_W-1:0]  upd_lba = '0;
    logic              upd_ready, alloc_req;
    logic              alloc_gnt = 1'b0;
    logic [PBA_W-1:0]  alloc_pba = '0;
    logic              rel_valid;
    logic [PBA_W-1:0]  rel_pba;
    logic              lk_valid = 1'b0;
    logic [LBA_W-1:0]  lk_lba = '0;
    logic              rsp_valid, rsp_mapped;
    logic [PBA_W-1:0]  rsp_pba;
    logic [FILL_W-1:0] rsp_fill;

    always #5 clk = ~clk;

    l2p_map #(.LBA_W(LBA_W), .PBA_W(PBA_W), .FILL_W(FILL_W)) i_l2p_map (.*);

    int total = 0, bad = 0;
    string phase = "R1";

    // reference model state
    bit               m_vld [DEPTH];
    int               m_pba [DEPTH];
    int               m_seed;
    bit               e_rsp_valid, e_rsp_mapped, e_rel_valid, e_bypass, e_zero;
    int               e_rsp_pba, e_rsp_fill, e_rel_pba;
    bit               e_rel_trim;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s (%s) %s actual=%0h expected=%0h", tag, phase, what, act, exp);
        end
    endtask

    // Model: evaluated from bench-driven inputs and its own state only.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_pba[i] = 0; end
            m_seed = fill_seed;
            e_rsp_valid = 0; e_rel_valid = 0;
        end else begin
            bit acc, bind_op, nv;
            int np;
            acc     = upd_valid && (upd_trim || alloc_gnt);
            bind_op = acc && !upd_trim;
            nv = m_vld[lk_lba]; np = m_pba[lk_lba];
            e_bypass = acc && (upd_lba == lk_lba);
            if (e_bypass) begin nv = bind_op; np = bind_op ? alloc_pba : 0; end
            e_rsp_valid  = lk_valid;
            e_rsp_mapped = nv;
            e_rsp_pba    = nv ? np : 0;
            e_zero       = cfg_zero_fill;
            e_rsp_fill   = (nv || cfg_zero_fill) ? 0 : m_seed;
            e_rel_valid  = acc && m_vld[upd_lba];
            e_rel_pba    = m_pba[upd_lba];
            e_rel_trim   = upd_trim;
            if (acc) begin
                m_vld[upd_lba] = bind_op;
                m_pba[upd_lba] = bind_op ? alloc_pba : 0;
            end
        end
    end

    // Registered outputs compared every cycle, away from the edge.
    always @(negedge clk) begin
        if (!rst) begin
            check(rsp_valid == e_rsp_valid, "R6", "rsp_valid", rsp_valid, e_rsp_valid);
            if (e_rsp_valid) begin
                check(rsp_mapped == e_rsp_mapped, e_bypass ? "R7" : "R3", "rsp_mapped",
                      rsp_mapped, e_rsp_mapped);
                check(rsp_pba == PBA_W'(e_rsp_pba), e_bypass ? "R7" : "R10", "rsp_pba",
                      rsp_pba, e_rsp_pba);
                check(rsp_fill == FILL_W'(e_rsp_fill),
                      e_rsp_mapped ? "R10" : (e_zero ? "R8" : "R9"), "rsp_fill",
                      rsp_fill, e_rsp_fill);
            end
            check(rel_valid == e_rel_valid, e_rel_trim ? "R5" : "R4", "rel_valid",
                  rel_valid, e_rel_valid);
            if (e_rel_valid)
                check(rel_pba == PBA_W'(e_rel_pba), e_rel_trim ? "R5" : "R4", "rel_pba",
                      rel_pba, e_rel_pba);
        end
    end

    task automatic step(bit uv, bit ut, int ul, bit g, int p, bit lv, int ll);
        @(negedge clk);
        upd_valid = uv; upd_trim = ut; upd_lba = LBA_W'(ul);
        alloc_gnt = g;  alloc_pba = PBA_W'(p);
        lk_valid  = lv; lk_lba = LBA_W'(ll);
        #1;
        check(alloc_req == (uv && !ut), "R2", "alloc_req", alloc_req, uv && !ut);
        if (uv) check(upd_ready == (ut || g), "R2", "upd_ready", upd_ready, ut || g);
    endtask

    task automatic sweep();
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 0, 1, i);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; upd_valid = 0; lk_valid = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        phase = "R1";
        sweep();
        phase = "R3";
        for (int i = 0; i < DEPTH; i++) step(1, 0, i, 1, 8'h10 + i, 0, 0);
        sweep();
        phase = "R4";
        step(1, 0, 2, 1, 8'h40, 0, 0);
        step(1, 0, 3, 1, 8'h41, 1, 3);
        step(0, 0, 0, 0, 0, 1, 3);
        phase = "R11";
        for (int i = 0; i < 4; i++) step(1, 0, 5, 0, 8'hEE, 1, 5);
        step(0, 0, 0, 0, 0, 1, 5);
        phase = "R5";
        step(1, 1, 2, 0, 0, 0, 0);
        step(1, 1, 2, 0, 0, 1, 2);
        step(0, 0, 0, 0, 0, 1, 2);
        phase = "R9";
        fill_seed = 16'h1234;
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 2);
        phase = "R8";
        cfg_zero_fill = 1'b1;
        step(0, 0, 0, 0, 0, 1, 2);
        cfg_zero_fill = 1'b0;
        step(0, 0, 0, 0, 0, 1, 2);
        phase = "R7";
        step(1, 0, 2, 1, 8'h77, 1, 2);
        step(1, 1, 3, 0, 0, 1, 3);
        step(1, 0, 3, 0, 8'h55, 1, 3);
        phase = "random";
        for (int i = 0; i < 400; i++) begin
            cfg_zero_fill = ($urandom_range(0, 3) == 0);
            step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, DEPTH - 1),
                 $urandom_range(0, 1), $urandom_range(0, 255),
                 $urandom_range(0, 1), $urandom_range(0, DEPTH - 1));
        end
        phase = "R1";
        cfg_zero_fill = 1'b0;
        fill_seed = 16'h0F0F;
        do_reset();
        sweep();
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        finish_run();
    end

endmodule